// File: doc/BRIEF.md
# Two-Layer Perceptron Sequencer

This block is the control and data-steering engine for a small two-layer perceptron face classifier. It does no arithmetic of its own. It drives an external floating-point multiplier and an external floating-point adder, each with a fixed pipeline latency. It reads weights and pixels from synchronous memories. It keeps the hidden-layer results in a local buffer. After a start pulse it works through every hidden node in turn. For each node it builds a sum of weight-times-pixel products, scales that sum by 0.75 to form the node's output, and stores it. It then runs the single output node over the stored hidden values in the same way.

The face/non-face decision is made with the adder. The block adds the threshold with its sign bit inverted, which subtracts it. The sign bit of the result is then read: a non-negative difference means face. The result is reported with a one-cycle done pulse. Values are treated as IEEE-style words whose top bit is the sign.

Top module: `nn_layer_seq`

## Requirements
- R1: During and after reset, until a start is accepted, done, faceOut, mulReq, addReq, wRdEn and pRdEn are all low.
- R2: Weight reads run through consecutive addresses starting at 0. Hidden node j term i reads address j*N_IN+i together with pixel address i. The output node term j reads address N_HID*N_IN+j with no pixel read.
- R3: Every node's accumulation starts from +0.0: the first add of each node has addA equal to all zeros.
- R4: Each node output is its sum multiplied by ACT_SCALE (0.75) through the multiplier, with no clamping. Hidden outputs feed the output node as its inputs.
- R5: The final add has addA equal to the output node value and addB equal to the threshold with bit DATA_W-1 inverted. faceOut is the inverse of bit DATA_W-1 of that sum, so an output exactly equal to the threshold is a face.
- R6: Memory data arrives one cycle after a read. mulReq is high in the cycle after every weight read, with mulA equal to the returned weight.
- R7: At most one arithmetic operation is in flight at a time. The run lasts N_HID*(N_IN+1)*(3+MUL_LAT+ADD_LAT) + (N_HID+1)*(1+MUL_LAT) + 1 + ADD_LAT cycles from the accepting edge to the edge that raises done.
- R8: done is high for exactly one cycle. faceOut is valid with it and is held until the next decision.
- R9: A start while a run is in progress is ignored: the run keeps its length and result, and no second run follows.
- R10: The threshold is captured when start is accepted. Later changes to thrIn have no effect on that run.
- R11: Each run issues N_HID*(N_IN+1)+N_HID+1 multiply requests, N_HID+1 of them with mulB equal to ACT_SCALE, and N_HID*(N_IN+1)+1 add requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts one classification when the block is idle |
| thrIn | input | DATA_W | Decision threshold |
| wRdEn | output | 1 | Weight memory read enable |
| wAddr | output | W_AW | Weight memory address |
| wData | input | DATA_W | Weight read data, one cycle after wRdEn |
| pRdEn | output | 1 | Pixel memory read enable |
| pAddr | output | P_AW | Pixel memory address |
| pData | input | DATA_W | Pixel read data, one cycle after pRdEn |
| mulReq | output | 1 | Multiply request |
| mulA | output | DATA_W | Multiplier operand A |
| mulB | output | DATA_W | Multiplier operand B |
| mulRes | input | DATA_W | Product, MUL_LAT cycles after the request |
| addReq | output | 1 | Add request |
| addA | output | DATA_W | Adder operand A |
| addB | output | DATA_W | Adder operand B |
| addRes | input | DATA_W | Sum, ADD_LAT cycles after the request |
| faceOut | output | 1 | Decision: 1 means face |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with DATA_W=64, N_IN=4, N_HID=3, MUL_LAT=2 and ADD_LAT=3, and models the arithmetic units with double-precision arithmetic. These sizes make a complete run only 136 cycles long, so every node boundary, the change from the hidden layer to the output layer, and the threshold step can each be hit many times. Because the two latencies differ, a wait counted against the wrong unit changes the run length and shows up as a failure. Small integer weights and pixels keep all sums exact, so a threshold placed exactly at the network output, or just above it, checks both the 0.75 scale and the sign-bit decision.

// File: rtl/nn_seq_pkg.sv
package nn_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_MULI, S_MULW, S_ADDI, S_ADDW,
    S_ACTI, S_ACTW, S_THRI, S_THRW
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // start accepted: capture threshold
    logic fetch;     // memory read cycle
    logic mulTerm;   // weight * input multiply
    logic mulAct;    // sum * scale multiply
    logic addTerm;   // acc + product
    logic addThr;    // output + (-threshold)
    logic capProd;
    logic capSum;
    logic clrAcc;
    logic wrHid;
    logic capAct;
    logic decide;
    logic layerOut;  // output-node pass
  } seqCtl_t;

endpackage

// File: rtl/nn_seq_ctrl.sv
module nn_seq_ctrl
  import nn_seq_pkg::*;
#(
  parameter int N_IN    = 400,
  parameter int N_HID   = 300,
  parameter int MUL_LAT = 2,
  parameter int ADD_LAT = 5,
  parameter int W_AW    = 18,
  parameter int T_W     = 9,
  parameter int H_AW    = 9,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output seqCtl_t          ctl,
  output logic [T_W-1:0]   termIdx,
  output logic [H_AW-1:0]  nodeIdx,
  output logic [W_AW-1:0]  wAddr
);

  seqState_t state;
  logic [LAT_W-1:0] latCnt;
  logic layerOut;
  logic mulDone, addDone, lastTerm, lastNode;

  assign mulDone  = (latCnt == LAT_W'(MUL_LAT - 1));
  assign addDone  = (latCnt == LAT_W'(ADD_LAT - 1));
  assign lastTerm = layerOut ? (termIdx == T_W'(N_HID - 1))
                             : (termIdx == T_W'(N_IN - 1));
  assign lastNode = (nodeIdx == H_AW'(N_HID - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      latCnt   <= '0;
      termIdx  <= '0;
      nodeIdx  <= '0;
      wAddr    <= '0;
      layerOut <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state    <= S_FETCH;
          termIdx  <= '0;
          nodeIdx  <= '0;
          wAddr    <= '0;
          layerOut <= 1'b0;
        end
        S_FETCH: state <= S_MULI;
        S_MULI: begin state <= S_MULW; latCnt <= '0; end
        S_MULW:
          if (mulDone) state <= S_ADDI;
          else latCnt <= latCnt + 1'b1;
        S_ADDI: begin state <= S_ADDW; latCnt <= '0; end
        S_ADDW:
          if (addDone) begin
            wAddr <= wAddr + 1'b1;
            if (lastTerm) state <= S_ACTI;
            else begin
              termIdx <= termIdx + 1'b1;
              state   <= S_FETCH;
            end
          end else latCnt <= latCnt + 1'b1;
        S_ACTI: begin state <= S_ACTW; latCnt <= '0; end
        S_ACTW:
          if (mulDone) begin
            if (layerOut) state <= S_THRI;
            else begin
              termIdx <= '0;
              state   <= S_FETCH;
              if (lastNode) begin
                layerOut <= 1'b1;
                nodeIdx  <= '0;
              end else nodeIdx <= nodeIdx + 1'b1;
            end
          end else latCnt <= latCnt + 1'b1;
        S_THRI: begin state <= S_THRW; latCnt <= '0; end
        S_THRW:
          if (addDone) state <= S_IDLE;
          else latCnt <= latCnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.layerOut = layerOut;
    ctl.load     = (state == S_IDLE) && start;
    ctl.fetch    = (state == S_FETCH);
    ctl.mulTerm  = (state == S_MULI);
    ctl.mulAct   = (state == S_ACTI);
    ctl.addTerm  = (state == S_ADDI);
    ctl.addThr   = (state == S_THRI);
    ctl.capProd  = (state == S_MULW) && mulDone;
    ctl.capSum   = (state == S_ADDW) && addDone;
    ctl.wrHid    = (state == S_ACTW) && mulDone && !layerOut;
    ctl.capAct   = (state == S_ACTW) && mulDone && layerOut;
    ctl.clrAcc   = ctl.load || ctl.wrHid;
    ctl.decide   = (state == S_THRW) && addDone;
  end

endmodule

// File: rtl/nn_seq_dp.sv
module nn_seq_dp
  import nn_seq_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          N_HID     = 300,
  parameter int          T_W       = 9,
  parameter int          H_AW      = 9,
  parameter logic [DATA_W-1:0] ACT_SCALE = 32'h3F40_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [T_W-1:0]    termIdx,
  input  logic [H_AW-1:0]   nodeIdx,
  input  logic [DATA_W-1:0] thrIn,
  input  logic [DATA_W-1:0] wData,
  input  logic [DATA_W-1:0] pData,
  input  logic [DATA_W-1:0] mulRes,
  input  logic [DATA_W-1:0] addRes,
  output logic              mulReq,
  output logic [DATA_W-1:0] mulA,
  output logic [DATA_W-1:0] mulB,
  output logic              addReq,
  output logic [DATA_W-1:0] addA,
  output logic [DATA_W-1:0] addB,
  output logic              faceOut,
  output logic              done
);

  logic [DATA_W-1:0] acc, prod, act, thrQ, hidRd;
  logic [DATA_W-1:0] hidBuf [N_HID];

  always_ff @(posedge clk) begin
    if (ctl.wrHid) hidBuf[nodeIdx] <= mulRes;
    if (ctl.fetch && ctl.layerOut) hidRd <= hidBuf[termIdx[H_AW-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0; prod <= '0; act <= '0; thrQ <= '0;
      faceOut <= 1'b0; done <= 1'b0;
    end else begin
      if (ctl.load)    thrQ <= thrIn;
      if (ctl.clrAcc)  acc <= '0;
      else if (ctl.capSum) acc <= addRes;
      if (ctl.capProd) prod <= mulRes;
      if (ctl.capAct)  act <= mulRes;
      if (ctl.decide)  faceOut <= ~addRes[DATA_W-1];
      done <= ctl.decide;
    end
  end

  assign mulReq = ctl.mulTerm | ctl.mulAct;
  assign mulA   = ctl.mulAct ? acc : wData;
  assign mulB   = ctl.mulAct ? ACT_SCALE : (ctl.layerOut ? hidRd : pData);
  assign addReq = ctl.addTerm | ctl.addThr;
  assign addA   = ctl.addThr ? act : acc;
  assign addB   = ctl.addThr ? {~thrQ[DATA_W-1], thrQ[DATA_W-2:0]} : prod;

endmodule

// File: rtl/nn_layer_seq.sv
module nn_layer_seq
  import nn_seq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_IN    = 400,
  parameter int N_HID   = 300,
  parameter int MUL_LAT = 2,
  parameter int ADD_LAT = 5,
  parameter logic [DATA_W-1:0] ACT_SCALE = 32'h3F40_0000,
  localparam int W_AW  = $clog2(N_IN * N_HID + N_HID),
  localparam int P_AW  = $clog2(N_IN),
  localparam int H_AW  = $clog2(N_HID),
  localparam int T_W   = $clog2((N_IN > N_HID) ? N_IN : N_HID),
  localparam int LAT_W = $clog2(((MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] thrIn,
  output logic              wRdEn,
  output logic [W_AW-1:0]   wAddr,
  input  logic [DATA_W-1:0] wData,
  output logic              pRdEn,
  output logic [P_AW-1:0]   pAddr,
  input  logic [DATA_W-1:0] pData,
  output logic              mulReq,
  output logic [DATA_W-1:0] mulA,
  output logic [DATA_W-1:0] mulB,
  input  logic [DATA_W-1:0] mulRes,
  output logic              addReq,
  output logic [DATA_W-1:0] addA,
  output logic [DATA_W-1:0] addB,
  input  logic [DATA_W-1:0] addRes,
  output logic              faceOut,
  output logic              done
);

  seqCtl_t          ctl;
  logic [T_W-1:0]   termIdx;
  logic [H_AW-1:0]  nodeIdx;

  nn_seq_ctrl #(
    .N_IN(N_IN), .N_HID(N_HID), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT),
    .W_AW(W_AW), .T_W(T_W), .H_AW(H_AW), .LAT_W(LAT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl),
    .termIdx(termIdx), .nodeIdx(nodeIdx), .wAddr(wAddr)
  );

  nn_seq_dp #(
    .DATA_W(DATA_W), .N_HID(N_HID), .T_W(T_W), .H_AW(H_AW),
    .ACT_SCALE(ACT_SCALE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .termIdx(termIdx), .nodeIdx(nodeIdx),
    .thrIn(thrIn), .wData(wData), .pData(pData), .mulRes(mulRes),
    .addRes(addRes), .mulReq(mulReq), .mulA(mulA), .mulB(mulB),
    .addReq(addReq), .addA(addA), .addB(addB), .faceOut(faceOut), .done(done)
  );

  assign wRdEn = ctl.fetch;
  assign pRdEn = ctl.fetch && !ctl.layerOut;
  assign pAddr = termIdx[P_AW-1:0];

endmodule

// File: rtl/nn_seq_chk.sv
module nn_seq_chk #(
  parameter int MUL_LAT = 2,
  parameter int ADD_LAT = 5,
  parameter int W_AW    = 18,
  localparam int G_W = $clog2(((MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT) + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            done,
  input logic            wRdEn,
  input logic [W_AW-1:0] wAddr,
  input logic            mulReq,
  input logic            addReq
);

  logic [G_W-1:0]  gapCnt;
  logic [W_AW-1:0] lastAddr;
  logic            haveLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      lastAddr <= '0;
      haveLast <= 1'b0;
    end else begin
      if (mulReq)      gapCnt <= G_W'(MUL_LAT);
      else if (addReq) gapCnt <= G_W'(ADD_LAT);
      else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (done) haveLast <= 1'b0;
      else if (wRdEn) begin
        haveLast <= 1'b1;
        lastAddr <= wAddr;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fetch_to_mul_R6: assert property (@(posedge clk) disable iff (!rstN)
    wRdEn |=> mulReq);

  assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mulReq || addReq) |-> (gapCnt == '0));

  assert_req_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(mulReq && addReq));

  assert_addr_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wRdEn && haveLast) |-> (wAddr == lastAddr + W_AW'(1)));

  assert_addr_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wRdEn && !haveLast) |-> (wAddr == '0));

endmodule

bind nn_layer_seq nn_seq_chk #(
  .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT), .W_AW(W_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .wRdEn(wRdEn), .wAddr(wAddr),
  .mulReq(mulReq), .addReq(addReq)
);

// File: tb/nn_layer_seq_tb.sv
`timescale 1ns/1ps
module nn_layer_seq_tb;

  localparam int NI = 4;
  localparam int NH = 3;
  localparam int ML = 2;
  localparam int AL = 3;
  localparam int DW = 64;
  localparam logic [63:0] SCALE = 64'h3FE8_0000_0000_0000; // 0.75
  localparam int W_AW = $clog2(NI * NH + NH);
  localparam int P_AW = $clog2(NI);
  localparam int RUN_LEN = NH*(NI+1)*(3+ML+AL) + (NH+1)*(1+ML) + 1 + AL;
  localparam int N_MUL = NH*(NI+1) + NH + 1;
  localparam int N_ADD = NH*(NI+1) + 1;

  localparam int NV = 6;
  localparam int VPIX [NV][NI] = '{
    '{1, 2, 3, 4}, '{0, 0, 0, 0}, '{9, 1, 5, 2},
    '{3, 7, 0, 6}, '{8, 8, 8, 8}, '{2, 0, 9, 1}};
  localparam int VTHRQ [NV] = '{1, 0, 4, -2, 3, 2}; // quarters

  logic clk = 0, rstN = 0, start = 0;
  logic [DW-1:0] thrIn = '0;
  logic wRdEn, pRdEn, mulReq, addReq, faceOut, done;
  logic [W_AW-1:0] wAddr;
  logic [P_AW-1:0] pAddr;
  logic [DW-1:0] wData, pData, mulA, mulB, mulRes, addA, addB, addRes;

  logic [DW-1:0] wMem [NI*NH+NH];
  logic [DW-1:0] pMem [NI];
  logic [DW-1:0] mulPipe [ML];
  logic [DW-1:0] addPipe [AL];

  int checks = 0, errors = 0;
  bit active = 0, prevRd = 0;
  int mulCnt, addCnt, actCnt, rdIdx;
  logic [DW-1:0] runThr;

  always #2.5 clk = ~clk;

  nn_layer_seq #(
    .DATA_W(DW), .N_IN(NI), .N_HID(NH), .MUL_LAT(ML), .ADD_LAT(AL),
    .ACT_SCALE(SCALE)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .thrIn(thrIn),
    .wRdEn(wRdEn), .wAddr(wAddr), .wData(wData),
    .pRdEn(pRdEn), .pAddr(pAddr), .pData(pData),
    .mulReq(mulReq), .mulA(mulA), .mulB(mulB), .mulRes(mulRes),
    .addReq(addReq), .addA(addA), .addB(addB), .addRes(addRes),
    .faceOut(faceOut), .done(done)
  );

  // memories and arithmetic unit models
  always_ff @(posedge clk) begin
    if (wRdEn) wData <= wMem[wAddr];
    if (pRdEn) pData <= pMem[pAddr];
    mulPipe[0] <= mulReq ? $realtobits($bitstoreal(mulA) * $bitstoreal(mulB)) : '0;
    for (int k = 1; k < ML; k++) mulPipe[k] <= mulPipe[k-1];
    addPipe[0] <= addReq ? $realtobits($bitstoreal(addA) + $bitstoreal(addB)) : '0;
    for (int k = 1; k < AL; k++) addPipe[k] <= addPipe[k-1];
  end
  assign mulRes = mulPipe[ML-1];
  assign addRes = addPipe[AL-1];

  function automatic int w1(int j, int i);
    return ((j * 5 + i * 3) % 7) - 3;
  endfunction
  function automatic int w2(int j);
    return (j % 2 == 0) ? 2 - j : -1;
  endfunction

  function automatic real refOut(int v);
    real h, s, o;
    o = 0.0;
    for (int j = 0; j < NH; j++) begin
      s = 0.0;
      for (int i = 0; i < NI; i++) s = s + real'(w1(j, i)) * real'(VPIX[v][i]);
      h = 0.75 * s;
      o = o + real'(w2(j)) * h;
    end
    return 0.75 * o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // port monitor during runs
  always @(negedge clk) begin
    if (active) begin
      if (prevRd) begin
        chk(mulReq, "R6 mulReq after read", 64'(mulReq), 64'd1);
        chk(mulA == wData, "R6 mulA weight", mulA, wData);
      end
      if (wRdEn) begin
        chk(wAddr == W_AW'(rdIdx), "R2 weight addr", 64'(wAddr), 64'(rdIdx));
        if (rdIdx < NI*NH) begin
          chk(pRdEn && pAddr == P_AW'(rdIdx % NI), "R2 pixel addr",
              64'(pAddr), 64'(rdIdx % NI));
        end else begin
          chk(!pRdEn, "R2 no pixel read on output node", 64'(pRdEn), 64'd0);
        end
        rdIdx++;
      end
      if (mulReq) begin
        mulCnt++;
        if (mulB == SCALE) actCnt++;
      end
      if (addReq) begin
        if ((addCnt < NI*NH && addCnt % NI == 0) || addCnt == NI*NH)
          chk(addA == '0, "R3 accumulator start", addA, 64'd0);
        if (addCnt == N_ADD - 1)
          chk(addB == {~runThr[63], runThr[62:0]}, "R5 negated threshold",
              addB, {~runThr[63], runThr[62:0]});
        addCnt++;
      end
    end
    prevRd = active && wRdEn;
  end

  task automatic loadPix(input int v);
    for (int i = 0; i < NI; i++) pMem[i] = $realtobits(real'(VPIX[v][i]));
  endtask

  task automatic runNet(input logic [63:0] thr, input bit midStart,
                        input bit midThr, output int cyc, output logic face);
    mulCnt = 0; addCnt = 0; actCnt = 0; rdIdx = 0; runThr = thr;
    @(negedge clk);
    thrIn = thr; start = 1; active = 1;
    @(posedge clk); #1 start = 0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (midStart && (cyc == 20 || cyc == 90)) start = 1;
      else start = 0;
      if (midThr && cyc == 5) thrIn = 64'h4059_0000_0000_0000; // 100.0
    end
    start = 0;
    face = faceOut;
    chk(cyc - 1 == RUN_LEN, "R7 run length", 64'(cyc - 1), 64'(RUN_LEN));
    chk(mulCnt == N_MUL, "R11 mul count", 64'(mulCnt), 64'(N_MUL));
    chk(actCnt == NH + 1, "R11 scale mul count", 64'(actCnt), 64'(NH + 1));
    chk(addCnt == N_ADD, "R11 add count", 64'(addCnt), 64'(N_ADD));
    @(negedge clk);
    active = 0;
    chk(!done, "R8 done one cycle", 64'(done), 64'd0);
    chk(faceOut == face, "R8 decision held", 64'(faceOut), 64'(face));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic face, faceRef;
    real o;
    for (int j = 0; j < NH; j++) begin
      for (int i = 0; i < NI; i++) wMem[j*NI+i] = $realtobits(real'(w1(j, i)));
      wMem[NI*NH+j] = $realtobits(real'(w2(j)));
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!done && !faceOut && !mulReq && !addReq && !wRdEn && !pRdEn,
        "R1 in reset", {58'd0, done, faceOut, mulReq, addReq, wRdEn, pRdEn}, 64'd0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(!done && !faceOut && !mulReq && !addReq && !wRdEn && !pRdEn,
        "R1 after reset", {58'd0, done, faceOut, mulReq, addReq, wRdEn, pRdEn}, 64'd0);

    // vector table: R4/R5 decisions
    for (int v = 0; v < NV; v++) begin
      loadPix(v);
      o = refOut(v);
      faceRef = (o - real'(VTHRQ[v]) / 4.0) >= 0.0;
      runNet($realtobits(real'(VTHRQ[v]) / 4.0), 0, 0, cyc, face);
      chk(face == faceRef, "R4 R5 vector decision", 64'(face), 64'(faceRef));
    end

    // R5: exact boundary is a face, just above is not
    loadPix(0);
    o = refOut(0);
    runNet($realtobits(o), 0, 0, cyc, face);
    chk(face == 1'b1, "R5 threshold equal to output", 64'(face), 64'd1);
    runNet($realtobits(o + 1.0 / 64.0), 0, 0, cyc, face);
    chk(face == 1'b0, "R4 R5 threshold just above output", 64'(face), 64'd0);
    runNet($realtobits(o - 1.0 / 64.0), 0, 0, cyc, face);
    chk(face == 1'b1, "R4 R5 threshold just below output", 64'(face), 64'd1);

    // R10: threshold change mid-run has no effect
    runNet($realtobits(o), 0, 1, cyc, face);
    chk(face == 1'b1, "R10 threshold captured at start", 64'(face), 64'd1);

    // R9: start during a run is ignored
    runNet($realtobits(o + 1.0 / 64.0), 1, 0, cyc, face);
    chk(face == 1'b0, "R9 result unchanged by extra start", 64'(face), 64'd0);
    begin
      int extra = 0;
      for (int k = 0; k < RUN_LEN + 20; k++) begin
        @(negedge clk);
        if (done || wRdEn || mulReq || addReq) extra++;
      end
      chk(extra == 0, "R9 no second run", 64'(extra), 64'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule